// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of eight 16-bit bus configuration registers from an external three-wire serial EEPROM when the chip comes out of reset. On the first bus clock after the active-low reset is released, it samples the sensed level of the EEPROM select pin. That pin has a pull-up, so a high level means a device is fitted. If no device is fitted, the block keeps the hard-wired defaults and reports completion at once.

When a device is present, the block reads word addresses 0 to 7 one after another. Each read is a complete serial command on a serial clock divided down from the bus clock. Each returned word goes to its own register offset. The offsets are scattered, so they follow a fixed mapping rather than the word address. For one of the words, only the upper byte is kept.

A combinational read port returns the value of any mapped offset at all times. A done flag rises in the same cycle that the last word becomes visible, or straight after a failed presence check, and stays high until the next reset.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, and after a load that does not run, the read port returns these defaults: 0x00→0x13A8, 0x02→0x0258, 0x08→0x0201, 0x0A→0x0700, 0x2C/0x2E/0x48/0x4A→0x0000.
- R2: If `ee_cs_sense_i` is low at the first clock edge after reset release, `ee_cs_o` never asserts, no register changes, and `done_o` is high two negedges after release.
- R3: Each word is read with its own select window, with `ee_cs_o` high during the window and low between windows. The command is the bits 1,1,0 followed by the 6-bit word address MSB first, and the addresses run 0 to 7 in order. `ee_di_o` changes only while `ee_sk_o` is low, and `ee_sk_o` is high only while `ee_cs_o` is high.
- R4: The one dummy bit that follows the address is discarded. The next 16 bits are taken MSB first, each sampled at a rising edge of `ee_sk_o`.
- R5: Words 0 to 7 land at offsets 0x00, 0x02, 0x08, 0x0A, 0x2C, 0x2E, 0x48 and 0x4A respectively.
- R6: At offset 0x08, only bits 15:8 of word 2 are stored. Bits 7:0 always read as the revision constant 0x01.
- R7: `done_o` rises in the same cycle that the word at 0x4A becomes readable, and it stays high until reset.
- R8: `done_o` is high no later than 65536 bus clocks after reset release.
- R9: An offset outside the eight mapped ones reads 0x0000. A register that has not yet been loaded reads its default.
- R10: The serial clock period is 2*HALF_DIV bus clocks, which is 4 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ee_cs_sense_i | input | 1 | Sensed level of the pulled-up EEPROM select pin |
| ee_cs_o | output | 1 | EEPROM select drive |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| rd_addr_i | input | 8 | Register read byte offset |
| rd_data_o | output | 16 | Register read data |
| done_o | output | 1 | Load complete or skipped |

## Verification
Two events share one clock edge: the store of the final word at offset 0x4A and the rise of `done_o`. The bench provokes this by parking the read port on 0x4A for the whole load and sampling it at every falling clock edge. At the first sample where `done_o` is high, the read must already show the loaded word. At the sample just before, it must still show the default. A one-cycle skew in either direction fails the check.

// File: rtl/cfg_ldr_pkg.sv
`timescale 1ns/1ps
package cfg_ldr_pkg;
  localparam int NWORDS   = 8;
  localparam int DATA_W   = 16;
  localparam int PART_IDX = 2;  // word holding only its upper byte

  typedef enum logic [1:0] {ST_SENSE, ST_XFER, ST_GAP, ST_DONE} ldr_state_e;

  function automatic logic [7:0] word_offset(int idx);
    case (idx)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h08;
      3: return 8'h0A;
      4: return 8'h2C;
      5: return 8'h2E;
      6: return 8'h48;
      default: return 8'h4A;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_default(int idx);
    case (idx)
      0: return 16'h13A8;
      1: return 16'h0258;
      2: return 16'h0200;
      3: return 16'h0700;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/ldr_sk_gen.sv
`timescale 1ns/1ps
module ldr_sk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sk_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CNT_MAX);
  assign rise_o = wrap && !sk_q;
  assign fall_o = wrap && sk_q;
  assign sk_o   = sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ldr_shift.sv
`timescale 1ns/1ps
module ldr_shift #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sdo_i,
  output logic              sdi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int LAST  = CMD_W + DATA_W;  // index of final data bit
  localparam int BW    = $clog2(LAST + 1);

  logic [BW-1:0]     bit_q;
  logic [DATA_W-2:0] sh_q;
  logic [CMD_W-1:0]  cmd;

  assign cmd = {3'b110, addr_i};

  always_comb begin
    sdi_o = 1'b0;
    if (int'(bit_q) < CMD_W) sdi_o = cmd[CMD_W - 1 - int'(bit_q)];
  end

  assign done_o = rise_i && (int'(bit_q) == LAST);
  assign data_o = {sh_q, sdo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      if (fall_i && int'(bit_q) != LAST) bit_q <= bit_q + 1'b1;
      // bit CMD_W is the dummy zero: skipped
      if (rise_i && int'(bit_q) > CMD_W) sh_q <= {sh_q[DATA_W-3:0], sdo_i};
    end
  end
endmodule

// File: rtl/ldr_cfg_regs.sv
`timescale 1ns/1ps
module ldr_cfg_regs
  import cfg_ldr_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h01,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [7:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] word_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    localparam logic [DATA_W-1:0] DEF = word_default(g);
    if (g == PART_IDX) begin : g_part
      logic [DATA_W-9:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          hi_q <= DEF[DATA_W-1:8];
        else if (we_i && widx_i == IW'(g))    hi_q <= wdata_i[DATA_W-1:8];
      end
      assign word_q[g] = {hi_q, REV_ID};
    end else begin : g_full
      logic [DATA_W-1:0] w_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          w_q <= DEF;
        else if (we_i && widx_i == IW'(g))    w_q <= wdata_i;
      end
      assign word_q[g] = w_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NWORDS; i++)
      if (rd_addr_i == word_offset(i)) rd_data_o = word_q[i];
  end
endmodule

// File: rtl/cfg_eeprom_loader.sv
`timescale 1ns/1ps
module cfg_eeprom_loader
  import cfg_ldr_pkg::*;
#(
  parameter int         HALF_DIV = 2,
  parameter int         GAP_CYC  = 4,
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] REV_ID   = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ee_cs_sense_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  input  logic [7:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  localparam int IW = $clog2(NWORDS);
  localparam int GW = $clog2(GAP_CYC + 1);

  ldr_state_e        state_q;
  logic [IW-1:0]     word_q;
  logic [GW-1:0]     gap_q;
  logic              xfer, sk_raw, sk_rise, sk_fall, sdi, word_done;
  logic [DATA_W-1:0] word_data;

  assign xfer = (state_q == ST_XFER);

  ldr_sk_gen #(.HALF_DIV(HALF_DIV)) u_sk (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(xfer),
    .sk_o  (sk_raw), .rise_o(sk_rise), .fall_o(sk_fall)
  );

  ldr_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!xfer),
    .rise_i(sk_rise), .fall_i(sk_fall), .addr_i(ADDR_W'(word_q)),
    .sdo_i (ee_do_i), .sdi_o(sdi), .done_o(word_done), .data_o(word_data)
  );

  ldr_cfg_regs #(.REV_ID(REV_ID)) u_regs (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(word_done), .widx_i(word_q),
    .wdata_i(word_data), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SENSE;
      word_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SENSE: state_q <= ee_cs_sense_i ? ST_XFER : ST_DONE;
        ST_XFER: if (word_done) begin
          if (word_q == IW'(NWORDS - 1)) state_q <= ST_DONE;
          else begin
            state_q <= ST_GAP;
            word_q  <= word_q + 1'b1;
            gap_q   <= '0;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(GAP_CYC - 1)) state_q <= ST_XFER;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign ee_cs_o = xfer;
  assign ee_sk_o = sk_raw && xfer;
  assign ee_di_o = sdi && xfer;
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/cfg_eeprom_loader_chk.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_chk #(
  parameter logic [7:0] REV_ID   = 8'h01,
  parameter int         DEADLINE = 65536
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ee_cs_o,
  input logic        ee_sk_o,
  input logic        ee_di_o,
  input logic [7:0]  rd_addr_i,
  input logic [15:0] rd_data_o,
  input logic        done_o
);
  logic [31:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cyc_q <= '0;
    else if (cyc_q < 32'(DEADLINE)) cyc_q <= cyc_q + 1'b1;
  end

  p_sk_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);
  p_di_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_sk_o) |-> $stable(ee_di_o));
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_idle_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ee_cs_o);
  p_deadline_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 32'(DEADLINE)) |-> done_o);
  p_rev_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 8'h08) |-> (rd_data_o[7:0] == REV_ID));
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk #(.REV_ID(REV_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o),
  .ee_di_o(ee_di_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .done_o(done_o)
);

// File: tb/cfg_eeprom_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sense = 1'b0;
  logic        cs, sk, di;
  logic        sdo = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;
  logic        done;

  always #5 clk = ~clk;

  cfg_eeprom_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_sense_i(sense), .ee_cs_o(cs),
    .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(sdo), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .done_o(done)
  );

  int total = 0;
  int bad   = 0;
  logic [15:0] mem [8];
  logic [5:0]  exp_q [$];
  logic        cs_seen = 1'b0;
  logic [7:0]  offs [8] = '{8'h00, 8'h02, 8'h08, 8'h0A, 8'h2C, 8'h2E, 8'h48, 8'h4A};
  logic [15:0] defs [8] = '{16'h13A8, 16'h0258, 16'h0201, 16'h0700, 16'h0, 16'h0, 16'h0, 16'h0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge cs) cs_seen = 1'b1;

  // EEPROM model and scoreboard monitor
  int      k = 0;
  logic [8:0]  cmd = '0;
  logic [15:0] cur = '0;
  realtime last_rise = 0;
  always @(negedge cs) k = 0;
  always @(posedge sk) begin
    if (k > 0) chk("R10 sk period", 32'(int'($realtime - last_rise)), 32'd40);
    last_rise = $realtime;
    k = k + 1;
    if (k <= 9) cmd = {cmd[7:0], di};
    if (k == 9) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", {23'd0, cmd}, 32'h1FF);
      else chk("R3 command", {23'd0, cmd}, {23'd0, 3'b110, exp_q.pop_front()});
      cur = mem[cmd[2:0]];
    end
    #1;
    if (k == 9) sdo = 1'b0;                       // dummy bit
    else if (k >= 10 && k <= 25) sdo = cur[25 - k];  // R4 MSB first
  end

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    sense = s;
    repeat (3) @(negedge clk);
    cs_seen = 1'b0;
    if (s) for (int i = 0; i < 8; i++) exp_q.push_back(6'(i));
    rst_n = 1'b1;
  endtask

  task automatic check_all(input string req, input logic use_mem);
    logic [15:0] d, e;
    for (int i = 0; i < 8; i++) begin
      rd(offs[i], d);
      if (!use_mem) e = defs[i];
      else if (i == 2) e = {mem[2][15:8], 8'h01};
      else e = mem[i];
      chk(req, {16'd0, d}, {16'd0, e});
    end
  endtask

  task automatic run_load(input string tag);
    logic [15:0] prev = 16'hxxxx;
    int cyc = 0;
    logic seen = 1'b0;
    while (!seen && cyc < 70000) begin
      @(negedge clk);
      rd_addr = 8'h4A;
      #1;
      cyc++;
      if (done) begin
        seen = 1'b1;
        chk({"R7 last word with done ", tag}, {16'd0, rd_data}, {16'd0, mem[7]});
        chk({"R7 default before done ", tag}, {16'd0, prev}, 32'h0);
      end else prev = rd_data;
    end
    chk({"R8 deadline ", tag}, {31'd0, cyc <= 65536}, 32'd1);
    chk({"R3 all reads issued ", tag}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 cs in reset", {31'd0, cs}, 32'd0);
    check_all("R1 default in reset", 1'b0);

    // R2 absent EEPROM
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    chk("R2 done quickly", {31'd0, done}, 32'd1);
    repeat (300) @(negedge clk);
    chk("R2 no select", {31'd0, cs_seen}, 32'd0);
    check_all("R2 defaults kept", 1'b0);
    rd(8'h04, d);  chk("R9 unmapped 04", {16'd0, d}, 32'h0);
    rd(8'h4C, d);  chk("R9 unmapped 4C", {16'd0, d}, 32'h0);

    // pattern A
    mem = '{16'h1234, 16'hBEEF, 16'hA55A, 16'h0C03, 16'h8001, 16'h7FFE, 16'hCAFE, 16'h0F0F};
    do_reset(1'b1);
    @(negedge clk);
    rd(8'h2C, d);  chk("R9 unloaded reads default", {16'd0, d}, 32'h0);
    run_load("A");
    check_all("R5 R6 map A", 1'b1);
    repeat (20) @(negedge clk);
    chk("R7 done sticky", {31'd0, done}, 32'd1);

    // pattern B
    mem = '{16'hFFFF, 16'h0001, 16'h00FF, 16'h8000, 16'h5555, 16'hAAAA, 16'h0100, 16'hFFFE};
    do_reset(1'b1);
    run_load("B");
    check_all("R4 R5 R6 map B", 1'b1);

    // absent again: defaults restored
    do_reset(1'b0);
    repeat (10) @(negedge clk);
    chk("R2 no select again", {31'd0, cs_seen}, 32'd0);
    check_all("R1 defaults restored", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule